// File: doc/BRIEF.md
# Set/Clear/Toggle Alias Register Bank

This block holds the 32-bit control registers of a clock and power controller behind a simple word-addressed bus. The 0x8000-byte space has two windows. A plain window at the bottom holds registers that are only ever overwritten whole. A second window, starting at byte offset 0x4000, holds registers that each take four consecutive words. The first word is the register itself. The other three are aliases that set, clear or flip selected bits, so software can change one field without a read-modify-write sequence. Reading an alias returns the register's value, and no read changes any register.

A small bus-response state machine, `ccm_bus_state_e`, produces the read and error responses one cycle after each request. It has four states: `ST_IDLE`, `ST_RD_OK`, `ST_RD_BAD` and `ST_WR_BAD`. The next state depends only on the request in the current cycle:
- A read of an address that has no register goes to `ST_RD_BAD`.
- Any other read goes to `ST_RD_OK`.
- A write to an address that has no register goes to `ST_WR_BAD`.
- Anything else returns to `ST_IDLE`.

Writes take effect at the request edge. A synchronous reset loads fixed default values into every register, including the lock-status flags of the PLL control registers.

Top module: `ccm_regbank`

## Requirements
- R1: `addr` is a word index, equal to the byte offset divided by four. Plain registers occupy words 0 to CTRL_WORDS-1 (32 by default). The aliased window starts at word 0x1000 (byte 0x4000) and spans four words per register: 16 registers, so words 0x1000 to 0x103F.
- R2: A read request (`rd_en` high at a clock edge) raises `rd_valid` for exactly the following cycle, with the data on `rd_data`. `rd_valid` stays low in every other cycle, and `rd_data` is zero whenever `rd_valid` is low.
- R3: A write to a plain register, or to the base word of an aliased register (offset 0 within its group of four), replaces all 32 bits.
- R4: A write to the base word + 1 of an aliased register ORs `wdata` into that register.
- R5: A write to the base word + 2 clears every register bit that is 1 in `wdata`.
- R6: A write to the base word + 3 XORs `wdata` into the register.
- R7: A read of any of the four words of an aliased register returns that register's value, and reads never modify a register.
- R8: Synchronous reset loads these defaults; every register not listed resets to zero.
  - Plain words 24 to 31 (the clock-gate registers) reset to 0xFFFFFFFF.
  - Aliased register 3 (system PLL control) resets to base value 0x00013001.
  - Aliased register 8 (fractional divider) resets to 0x1018101B.
  - Aliased registers 0, 1, 2, 4, 5, 6 and 7 reset to base values 0x00013063, 0x00012000, 0x00012000, 0x00011006, 0x0001100C, 0x00011001 and 0x1311100C.
- R9: At reset, aliased registers 0 to 6 (the PLL control registers) also have their lock bit, bit 31, set on top of the base value. For example, register 3 reads 0x80013001.
- R10: A read of an address outside both windows returns zero with `rd_valid` high. `err` is high for that same single response cycle.
- R11: A write to an address outside both windows changes no register and raises `err` for the single following cycle.
- R12: A read and a write to the same address in the same cycle return the value held before the write; the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads defaults |
| addr | input | 13 | Word index into the 0x8000-byte space |
| rd_en | input | 1 | Read request strobe |
| wr_en | input | 1 | Write request strobe |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid, else zero |
| rd_valid | output | 1 | Read response, one cycle after rd_en |
| err | output | 1 | One-cycle pulse after an access to an unmapped address |

## Verification
Register state is only visible through reads, and any corrupted bit appears in the `rd_data` of the next read of that register, one cycle after the request. A decode fault shows up in one of two ways. It can send an alias write to the wrong register or the wrong operation, which appears as a mismatch on the next read of either register. Or it can let an out-of-range address fold onto a real register through a truncated index, which appears when that register is read after the stray write. A wrong bus-response state shows on `rd_valid` or `err` in the very next cycle. The scoreboard checks both outputs on every cycle that follows a request, and flags any response that arrives with no request pending.

// File: rtl/ccm_bank_pkg.sv
package ccm_bank_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 13;   // 0x8000 bytes / 4

    typedef enum logic [1:0] {
        OP_BASE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_TOG  = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_PLAIN = 2'd1,
        WIN_ALIAS = 2'd2
    } window_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_OK  = 2'd1,
        ST_RD_BAD = 2'd2,
        ST_WR_BAD = 2'd3
    } ccm_bus_state_e;

    // Base reset value of an aliased register (lock flag added separately)
    function automatic logic [WORD_W-1:0] alias_reset_base(input int unsigned slot);
        case (slot)
            0:       return 32'h0001_3063;
            1:       return 32'h0001_2000;
            2:       return 32'h0001_2000;
            3:       return 32'h0001_3001;
            4:       return 32'h0001_1006;
            5:       return 32'h0001_100C;
            6:       return 32'h0001_1001;
            7:       return 32'h1311_100C;
            8:       return 32'h1018_101B;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Reset value of a plain register: gate registers at the top are all ones
    function automatic logic [WORD_W-1:0] plain_reset(input int unsigned slot,
                                                      input int unsigned gate_first);
        return (slot >= gate_first) ? 32'hFFFF_FFFF : 32'h0000_0000;
    endfunction

endpackage

// File: rtl/ccm_addr_decode.sv
module ccm_addr_decode
    import ccm_bank_pkg::*;
#(
    parameter int unsigned CTRL_WORDS = 32,
    parameter int unsigned ALIAS_REGS = 16,
    parameter int unsigned ALIAS_BASE = 'h1000,
    localparam int unsigned PIDX_W    = $clog2(CTRL_WORDS),
    localparam int unsigned AIDX_W    = $clog2(ALIAS_REGS),
    localparam int unsigned SPAN      = ALIAS_REGS * 4
) (
    input  logic [ADDR_W-1:0] addr,
    output window_e           win,
    output logic [PIDX_W-1:0] plain_idx,
    output logic [AIDX_W-1:0] alias_idx,
    output alias_op_e         op
);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - ADDR_W'(ALIAS_BASE);
        if (addr < ADDR_W'(CTRL_WORDS)) begin
            win = WIN_PLAIN;
        end else if ((addr >= ADDR_W'(ALIAS_BASE)) && (off < ADDR_W'(SPAN))) begin
            win = WIN_ALIAS;
        end else begin
            win = WIN_NONE;
        end
        plain_idx = addr[PIDX_W-1:0];
        alias_idx = off[AIDX_W+1:2];
        op        = alias_op_e'(off[1:0]);
    end

endmodule

// File: rtl/ccm_plain_file.sv
module ccm_plain_file
    import ccm_bank_pkg::*;
#(
    parameter int unsigned WORDS      = 32,
    parameter int unsigned GATE_FIRST = 24,
    localparam int unsigned PIDX_W    = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_stb,
    input  logic [PIDX_W-1:0]             idx,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORDS-1:0][WORD_W-1:0]  regs_q
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [WORD_W-1:0] RST_VAL = plain_reset(g, GATE_FIRST);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= RST_VAL;
            end else if (wr_stb && (idx == PIDX_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/ccm_alias_file.sv
module ccm_alias_file
    import ccm_bank_pkg::*;
#(
    parameter int unsigned REGS     = 16,
    parameter int unsigned PLL_REGS = 7,
    parameter int unsigned LOCK_BIT = 31,
    localparam int unsigned AIDX_W  = $clog2(REGS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_stb,
    input  logic [AIDX_W-1:0]            idx,
    input  alias_op_e                    op,
    input  logic [WORD_W-1:0]            wdata,
    output logic [REGS-1:0][WORD_W-1:0]  regs_q
);

    localparam logic [WORD_W-1:0] LOCK_MASK = WORD_W'(1) << LOCK_BIT;

    for (genvar g = 0; g < REGS; g++) begin : g_reg
        logic [WORD_W-1:0] rst_val;
        if (g < PLL_REGS) begin : g_pll
            assign rst_val = alias_reset_base(g) | LOCK_MASK;
        end else begin : g_other
            assign rst_val = alias_reset_base(g);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= rst_val;
            end else if (wr_stb && (idx == AIDX_W'(g))) begin
                unique case (op)
                    OP_BASE: regs_q[g] <= wdata;
                    OP_SET:  regs_q[g] <= regs_q[g] | wdata;
                    OP_CLR:  regs_q[g] <= regs_q[g] & ~wdata;
                    OP_TOG:  regs_q[g] <= regs_q[g] ^ wdata;
                endcase
            end
        end
    end

endmodule

// File: rtl/ccm_regbank.sv
module ccm_regbank
    import ccm_bank_pkg::*;
#(
    parameter int unsigned CTRL_WORDS     = 32,
    parameter int unsigned GATE_FIRST     = 24,
    parameter int unsigned ALIAS_REGS     = 16,
    parameter int unsigned PLL_REGS       = 7,
    parameter int unsigned LOCK_BIT       = 31,
    parameter int unsigned ALIAS_BYTE_OFS = 'h4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              err
);

    localparam int unsigned ALIAS_BASE = ALIAS_BYTE_OFS / 4;
    localparam int unsigned PIDX_W     = $clog2(CTRL_WORDS);
    localparam int unsigned AIDX_W     = $clog2(ALIAS_REGS);

    window_e                             win;
    logic [PIDX_W-1:0]                   pidx;
    logic [AIDX_W-1:0]                   aidx;
    alias_op_e                           op;
    logic [CTRL_WORDS-1:0][WORD_W-1:0]   plain_q;
    logic [ALIAS_REGS-1:0][WORD_W-1:0]   alias_q;
    logic [WORD_W-1:0]                   rd_word;
    logic [WORD_W-1:0]                   hold_q;
    logic                                miss;
    ccm_bus_state_e                      state_q, state_d;

    ccm_addr_decode #(
        .CTRL_WORDS (CTRL_WORDS),
        .ALIAS_REGS (ALIAS_REGS),
        .ALIAS_BASE (ALIAS_BASE)
    ) dec_i (
        .addr      (addr),
        .win       (win),
        .plain_idx (pidx),
        .alias_idx (aidx),
        .op        (op)
    );

    assign miss = (win == WIN_NONE);

    ccm_plain_file #(
        .WORDS      (CTRL_WORDS),
        .GATE_FIRST (GATE_FIRST)
    ) plain_i (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_en && (win == WIN_PLAIN)),
        .idx    (pidx),
        .wdata  (wdata),
        .regs_q (plain_q)
    );

    ccm_alias_file #(
        .REGS     (ALIAS_REGS),
        .PLL_REGS (PLL_REGS),
        .LOCK_BIT (LOCK_BIT)
    ) alias_i (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_en && (win == WIN_ALIAS)),
        .idx    (aidx),
        .op     (op),
        .wdata  (wdata),
        .regs_q (alias_q)
    );

    // Read source: every alias word of a group maps onto its base register
    always_comb begin
        unique case (win)
            WIN_PLAIN: rd_word = plain_q[pidx];
            WIN_ALIAS: rd_word = alias_q[aidx];
            default:   rd_word = '0;
        endcase
    end

    // Captured at the request edge, before any same-cycle write lands
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (rd_en && !miss) begin
            hold_q <= rd_word;
        end
    end

    // Bus response state machine
    always_comb begin
        if (rd_en && miss) begin
            state_d = ST_RD_BAD;
        end else if (rd_en) begin
            state_d = ST_RD_OK;
        end else if (wr_en && miss) begin
            state_d = ST_WR_BAD;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                rd_valid = 1'b0;
                err      = 1'b0;
                rd_data  = '0;
            end
            ST_RD_OK: begin
                rd_valid = 1'b1;
                err      = 1'b0;
                rd_data  = hold_q;
            end
            ST_RD_BAD: begin
                rd_valid = 1'b1;
                err      = 1'b1;
                rd_data  = '0;
            end
            ST_WR_BAD: begin
                rd_valid = 1'b0;
                err      = 1'b1;
                rd_data  = '0;
            end
        endcase
    end

endmodule

// File: rtl/ccm_bank_checker.sv
module ccm_bank_checker #(
    parameter int unsigned CTRL_WORDS = 32,
    parameter int unsigned ALIAS_REGS = 16,
    parameter int unsigned ALIAS_BASE = 'h1000
) (
    input logic                        clk,
    input logic                        rst,
    input logic [12:0]                 addr,
    input logic                        rd_en,
    input logic                        wr_en,
    input logic [31:0]                 wdata,
    input logic [31:0]                 rd_data,
    input logic                        rd_valid,
    input logic                        err,
    input logic [ALIAS_REGS-1:0][31:0] alias_q
);

    logic [31:0] a32;
    logic        unmapped;

    assign a32      = 32'(addr);
    assign unmapped = !((a32 < 32'(CTRL_WORDS)) ||
                        ((a32 >= 32'(ALIAS_BASE)) && (a32 < 32'(ALIAS_BASE + 4 * ALIAS_REGS))));

    p_rd_resp_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && rd_data == 32'h0));
    p_bad_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && unmapped) |=> (err && rd_data == 32'h0));
    p_bad_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && unmapped) |=> err);
    p_err_only_bad_r11: assert property (@(posedge clk) disable iff (rst)
        !((rd_en || wr_en) && unmapped) |=> !err);
    p_read_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(alias_q));

    for (genvar g = 0; g < ALIAS_REGS; g++) begin : g_slot
        localparam int unsigned W0 = ALIAS_BASE + 4 * g;
        p_base_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && a32 == 32'(W0)) |=> alias_q[g] == $past(wdata));
        p_set_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && a32 == 32'(W0 + 1)) |=> alias_q[g] == ($past(alias_q[g]) | $past(wdata)));
        p_clr_r5: assert property (@(posedge clk) disable iff (rst)
            (wr_en && a32 == 32'(W0 + 2)) |=> alias_q[g] == ($past(alias_q[g]) & ~$past(wdata)));
        p_tog_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_en && a32 == 32'(W0 + 3)) |=> alias_q[g] == ($past(alias_q[g]) ^ $past(wdata)));
        // old value is returned even with a same-cycle write (R12)
        p_alias_read_r7: assert property (@(posedge clk) disable iff (rst)
            (rd_en && a32 >= 32'(W0) && a32 <= 32'(W0 + 3)) |=> rd_data == $past(alias_q[g]));
    end

endmodule

bind ccm_regbank ccm_bank_checker #(
    .CTRL_WORDS (CTRL_WORDS),
    .ALIAS_REGS (ALIAS_REGS),
    .ALIAS_BASE (ALIAS_BASE)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .err      (err),
    .alias_q  (alias_q)
);

// File: tb/ccm_regbank_tb_top.sv
module ccm_regbank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AB         = 'h1000;   // aliased window, word index (R1)
    localparam int NPLAIN     = 32;
    localparam int NALIAS     = 16;

    typedef struct {
        logic        valid;
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic acc_q = 1'b0;

    exp_t        sb[$];
    logic [31:0] pm[NPLAIN];
    logic [31:0] am[NALIAS];

    always #(CLK_PERIOD/2) clk = ~clk;

    ccm_regbank dut_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .err      (err)
    );

    // Reference defaults (R8, R9)
    task automatic model_reset();
        for (int i = 0; i < NPLAIN; i++) pm[i] = (i >= 24) ? 32'hFFFF_FFFF : 32'h0;
        for (int i = 0; i < NALIAS; i++) am[i] = 32'h0;
        am[0] = 32'h8001_3063; am[1] = 32'h8001_2000; am[2] = 32'h8001_2000;
        am[3] = 32'h8001_3001; am[4] = 32'h8001_1006; am[5] = 32'h8001_100C;
        am[6] = 32'h8001_1001; am[7] = 32'h1311_100C; am[8] = 32'h1018_101B;
    endtask

    function automatic bit unmapped(input int a);
        return !((a < NPLAIN) || (a >= AB && a < AB + 4 * NALIAS));
    endfunction

    function automatic logic [31:0] model_read(input int a);
        if (a < NPLAIN) return pm[a];
        if (!unmapped(a)) return am[(a - AB) / 4];
        return 32'h0;
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        if (a < NPLAIN) begin
            pm[a] = d;
        end else if (!unmapped(a)) begin
            case ((a - AB) % 4)
                0: am[(a - AB) / 4] = d;
                1: am[(a - AB) / 4] = am[(a - AB) / 4] | d;
                2: am[(a - AB) / 4] = am[(a - AB) / 4] & ~d;
                default: am[(a - AB) / 4] = am[(a - AB) / 4] ^ d;
            endcase
        end
    endtask

    task automatic bus_access(input bit do_rd, input bit do_wr, input int a,
                              input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        addr  = 13'(a);
        rd_en = do_rd;
        wr_en = do_wr;
        wdata = d;
        e.valid = do_rd;
        e.data  = do_rd ? model_read(a) : 32'h0;
        e.err   = unmapped(a);
        e.tag   = tag;
        sb.push_back(e);
        if (do_wr) model_write(a, d);
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        bus_access(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        bus_access(1'b0, 1'b1, a, d, tag);
    endtask

    always @(posedge clk) acc_q <= rst ? 1'b0 : (rd_en | wr_en);

    // Monitor: compares each response against the queued expectation
    always @(negedge clk) begin
        if (!rst) begin
            if (acc_q) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL scoreboard empty: got valid=%0b data=%h err=%0b expected a queued item",
                             rd_valid, rd_data, err);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    checks++;
                    if (rd_valid !== e.valid || rd_data !== e.data || err !== e.err) begin
                        fails++;
                        $display("FAIL %s: got valid=%0b data=%h err=%0b expected valid=%0b data=%h err=%0b",
                                 e.tag, rd_valid, rd_data, err, e.valid, e.data, e.err);
                    end
                end
            end else if (rd_valid || err) begin
                checks++; fails++;
                $display("FAIL R2 unrequested response: got valid=%0b err=%0b expected 0/0", rd_valid, err);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0 || err !== 1'b0 || rd_data !== 32'h0) begin
            fails++;
            $display("FAIL R2 reset outputs: got valid=%0b err=%0b data=%h expected 0/0/0", rd_valid, err, rd_data);
        end

        // R8 / R9 reset defaults, R1 window placement
        rd(AB + 12, "R9 system PLL ctrl with lock bit");
        rd(AB + 32, "R8 fractional divider default");
        rd(AB + 0,  "R9 PLL reg0 lock bit");
        rd(AB + 28, "R8 reg7 default");
        rd(24, "R8 first gate register");
        rd(31, "R8 last gate register");
        rd(0,  "R1 plain word 0 zero");
        rd(AB + 60, "R1 last aliased register");

        // R7 aliases read the base register, no side effect
        rd(AB + 13, "R7 set alias read");
        rd(AB + 14, "R7 clear alias read");
        rd(AB + 15, "R7 toggle alias read");
        rd(AB + 15, "R7 repeated read unchanged");

        // R4 / R5 / R6 alias writes
        wr(AB + 33, 32'h0000_0F00, "R4 set write");
        rd(AB + 32, "R4 set result");
        wr(AB + 34, 32'h1000_001B, "R5 clear write");
        rd(AB + 32, "R5 clear result");
        wr(AB + 35, 32'hFFFF_0000, "R6 toggle write");
        rd(AB + 32, "R6 toggle result");
        wr(AB + 35, 32'hFFFF_0000, "R6 toggle back");
        rd(AB + 35, "R6 toggle restored");
        wr(AB + 14, 32'h8000_0000, "R5 clear lock bit");
        rd(AB + 12, "R5 lock bit cleared");
        wr(AB + 41, 32'h0000_0003, "R4 set on zero register");
        rd(AB + 40, "R4 set on zero result");

        // R3 full replacement
        wr(AB + 32, 32'hCAFE_F00D, "R3 base word write");
        rd(AB + 33, "R3 base word result");
        wr(5, 32'h1234_5678, "R3 plain write");
        rd(5, "R3 plain result");
        wr(31, 32'h0000_0001, "R3 plain gate write");
        rd(31, "R3 plain gate result");

        // R10 / R11 unmapped accesses
        rd(NPLAIN, "R10 read just past plain window");
        rd(AB - 1, "R10 read just below aliased window");
        rd(AB + 64, "R10 read just past aliased window");
        rd('h1FFF, "R10 read top word");
        wr(NPLAIN, 32'hDEAD_BEEF, "R11 write past plain window");
        rd(0, "R11 plain word 0 untouched");
        wr(AB + 64, 32'hDEAD_BEEF, "R11 write past aliased window");
        rd(AB + 0, "R11 aliased reg0 untouched");
        wr('h0800, 32'hFFFF_FFFF, "R11 write in gap");
        rd(5, "R11 plain word 5 untouched");

        // R12 same-cycle read and write
        bus_access(1'b1, 1'b1, 5, 32'h0BAD_F00D, "R12 plain read returns old");
        rd(5, "R12 plain new value visible");
        bus_access(1'b1, 1'b1, AB + 13, 32'h0000_00F0, "R12 alias read returns old");
        rd(AB + 12, "R12 alias set applied");

        // R9 reset restores lock bits and defaults
        do_reset();
        rd(AB + 12, "R9 lock bit restored after reset");
        rd(AB + 32, "R8 divider restored after reset");
        rd(5, "R8 plain restored after reset");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard leftover: got %0d items expected 0", sb.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule